// File: doc/BRIEF.md
# USB Host Clock and Reset Bring-up Sequencer

This block brings a USB host controller's clocks and resets out of their power-up state in a fixed order. It runs from the I/O clock and drives the interface clock enable, the PHY power-on and test resets, the PHY and host resets, and the enable and reset of two clock dividers. One divider feeds the host and the other feeds the OHCI-side clocks. Each change is followed by a minimum settling wait, counted in I/O clock cycles. Every wait is derived from the `IO_CLK_KHZ` parameter and rounded up.

Several clients may ask for the host. Start requests are reference-counted, so only the request that lifts the count from zero launches the sequence. Stop requests only lower the count. If the host reset is already released when a sequence begins, the reset work is skipped and only the final programming step runs. That step writes the per-port PHY tuning values and the frame-length adjustment. The host divider ratio comes from a quantised table indexed by the I/O clock frequency in MHz divided by 130.

Top module: `usb_bringup_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, every control output holds its initial state: `phy_por`=1, `if_clk_en`=0 and `phy_test_rst`=0. All four active-low resets (`phy_rst_n`, `host_rst_n`, `hdiv_rst_n`, `odiv_rst_n`) are 0 and both divider enables are 0. `hdiv_val`, all port tuning fields and `frame_len_adj` are 0, and `busy`=0 and `done`=0.
- R2: A one-cycle `start_req` with `stop_req` low increments a saturating count. It launches the sequence only if the count was 0 and the sequencer is idle, and `busy` is then 1 after that edge. `stop_req` alone decrements the count, stopping at 0, and changes no control output. `start_req` and `stop_req` together leave the count unchanged and launch nothing.
- R3: `if_clk_en` becomes 1 one cycle after `busy` rises. If `host_rst_n` is already 1 at that point, the port programming step happens one cycle later, so `done` rises three cycles after `busy`.
- R4: `hdiv_val` = f(q) with q = `io_clk_mhz`/130, rounded down. The mapping is: q=0 gives 1; q=1..4 gives q; q=5 gives 4; q=6..7 gives 6; q=8..11 gives 8; q>=12 gives 12.
- R5: In a full run, the initial state is re-applied and `hdiv_val` is loaded. One cycle later `hdiv_en` rises, and one cycle after that `hdiv_rst_n` rises.
- R6: `phy_por` falls 65 cycles after `hdiv_rst_n` rises. `phy_test_rst` rises 1 ms of cycles + 1 later and stays high for the 10 ns cycle count + 1.
- R7: `odiv_rst_n` rises the 20 ns cycle count + 1 after `phy_test_rst` falls, and `odiv_en` rises one cycle later. `phy_rst_n` rises 65 cycles after that.
- R8: `host_rst_n` rises the 1 us cycle count + 1 after `phy_rst_n` rises. The port programming step follows one cycle later.
- R9: In the port programming step, each port gets TX reference tune 15 (4 bits, port n at bits [4n+3:4n]), rise tune 1 and pre-emphasis tune 1 (2 bits each, port n at [2n+1:2n]). `frame_len_adj` gets 0x20. In the same step `busy` falls and `done` pulses high for exactly one cycle.
- R10: The wait cycle counts are ceil(t * `IO_CLK_KHZ` * 1000) for t = 1 ms, 1 us, 10 ns and 20 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Start request pulse |
| stop_req | input | 1 | Stop request pulse |
| io_clk_mhz | input | FREQ_W (12) | I/O clock frequency in MHz |
| if_clk_en | output | 1 | Interface clock enable |
| phy_por | output | 1 | PHY power-on reset, active high |
| phy_test_rst | output | 1 | PHY test reset, active high |
| phy_rst_n | output | 1 | PHY reset, active low |
| host_rst_n | output | 1 | Host reset, active low |
| hdiv_en | output | 1 | Host divider enable |
| hdiv_rst_n | output | 1 | Host divider reset, active low |
| odiv_en | output | 1 | OHCI divider enable |
| odiv_rst_n | output | 1 | OHCI divider reset, active low |
| hdiv_val | output | 4 | Host divider ratio |
| port_vref_tune | output | NUM_PORTS*4 | TX reference tune per port |
| port_rise_tune | output | NUM_PORTS*2 | Rise tune per port |
| port_preemph_tune | output | NUM_PORTS*2 | Pre-emphasis tune per port |
| frame_len_adj | output | 6 | Frame-length adjustment |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every output is registered. An accepted start therefore shows on `busy` one edge later, and each following step lands a fixed number of edges after the previous one. Those gaps are one edge for back-to-back steps and the wait count plus one after a timed wait. The bench's behavioural model replays exactly that schedule from a queue of (gap, action) pairs and updates at the rising edge. All outputs are compared at the falling edge of the same cycle. Two wait lengths are also measured directly between output transitions and checked against counts rounded up independently with real arithmetic.

// File: rtl/ubs_pkg.sv
package ubs_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_IFEN, ST_CHECK, ST_INIT, ST_HDIV, ST_HDIV_EN, ST_HDIV_REL,
    ST_WAIT_A, ST_POR_REL, ST_WAIT_MS, ST_TRST_ON, ST_WAIT_P, ST_TRST_OFF,
    ST_WAIT_S, ST_ODIV_REL, ST_ODIV_EN, ST_WAIT_B, ST_PRST_REL, ST_WAIT_US,
    ST_HRST_REL, ST_PORTS
  } seq_state_e;

  typedef logic [3:0] hdiv_t;

  // Quantised host divider ratio from the frequency-over-130 MHz quotient.
  function automatic hdiv_t pick_hdiv(input int unsigned q);
    hdiv_t r;
    if (q == 0)       r = 4'd1;
    else if (q <= 4)  r = hdiv_t'(q);
    else if (q == 5)  r = 4'd4;
    else if (q <= 7)  r = 4'd6;
    else if (q <= 11) r = 4'd8;
    else              r = 4'd12;
    return r;
  endfunction

endpackage

// File: rtl/ubs_refcnt.sv
module ubs_refcnt #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic stop_req,
  output logic go
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up, dn;

  assign up = start_req && !stop_req;
  assign dn = stop_req && !start_req;
  assign go = up && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (up && cnt_q != CNT_MAX)  cnt_d = cnt_q + 1'b1;
    else if (dn && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && stop_req && !start_req) |=> cnt_q == '0)
    else $error("stop below zero changed the count");

  p_first_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> cnt_q == CNT_W'(1))
    else $error("launching start did not leave count at one");

endmodule

// File: rtl/ubs_timer.sv
module ubs_timer #(
  parameter int TMR_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             expired
);
  logic [TMR_W-1:0] cnt_q;

  assign expired = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val))
    else $error("wait counter missed its load");

  p_rest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> cnt_q == '0)
    else $error("expired wait counter moved on its own");

endmodule

// File: rtl/ubs_portcfg.sv
module ubs_portcfg #(
  parameter int NUM_PORTS = 2,
  parameter int VREF_W    = 4,
  parameter int RISE_W    = 2,
  parameter int PRE_W     = 2,
  parameter int VREF_VAL  = 15,
  parameter int RISE_VAL  = 1,
  parameter int PRE_VAL   = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  output logic [NUM_PORTS*VREF_W-1:0] vref,
  output logic [NUM_PORTS*RISE_W-1:0] rise,
  output logic [NUM_PORTS*PRE_W-1:0]  pre
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [VREF_W-1:0] vref_q;
    logic [RISE_W-1:0] rise_q;
    logic [PRE_W-1:0]  pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vref_q <= '0;
        rise_q <= '0;
        pre_q  <= '0;
      end else if (wr_en) begin
        vref_q <= VREF_W'(VREF_VAL);
        rise_q <= RISE_W'(RISE_VAL);
        pre_q  <= PRE_W'(PRE_VAL);
      end
    end

    assign vref[p*VREF_W +: VREF_W] = vref_q;
    assign rise[p*RISE_W +: RISE_W] = rise_q;
    assign pre[p*PRE_W +: PRE_W]    = pre_q;
  end

endmodule

// File: rtl/usb_bringup_seq.sv
module usb_bringup_seq
  import ubs_pkg::*;
#(
  parameter int unsigned IO_CLK_KHZ = 800_000,
  parameter int          FREQ_W     = 12,
  parameter int          NUM_PORTS  = 2,
  parameter int          DIV_WAIT   = 64,
  parameter int          REF_W      = 8,
  parameter int          FLA_W      = 6,
  parameter int          FLA_VAL    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_req,
  input  logic                   stop_req,
  input  logic [FREQ_W-1:0]      io_clk_mhz,
  output logic                   if_clk_en,
  output logic                   phy_por,
  output logic                   phy_test_rst,
  output logic                   phy_rst_n,
  output logic                   host_rst_n,
  output logic                   hdiv_en,
  output logic                   hdiv_rst_n,
  output logic                   odiv_en,
  output logic                   odiv_rst_n,
  output logic [3:0]             hdiv_val,
  output logic [NUM_PORTS*4-1:0] port_vref_tune,
  output logic [NUM_PORTS*2-1:0] port_rise_tune,
  output logic [NUM_PORTS*2-1:0] port_preemph_tune,
  output logic [FLA_W-1:0]       frame_len_adj,
  output logic                   busy,
  output logic                   done
);
  // Minimum waits in I/O clock cycles, rounded up.
  localparam int unsigned W_MS     = IO_CLK_KHZ;
  localparam int unsigned W_US     = (IO_CLK_KHZ + 999) / 1000;
  localparam int unsigned W_PULSE  = (IO_CLK_KHZ * 10 + 999_999) / 1_000_000;
  localparam int unsigned W_SETTLE = (IO_CLK_KHZ * 20 + 999_999) / 1_000_000;
  localparam int unsigned W_MAX    = (W_MS > DIV_WAIT) ? W_MS : DIV_WAIT;
  localparam int          TMR_W    = $clog2(W_MAX + 1);
  localparam int          RATIO    = 130;

  seq_state_e        state_q, state_d;
  logic              go, tmr_load, tmr_done, cfg_wr;
  logic [TMR_W-1:0]  tmr_val;
  logic [FREQ_W-1:0] ratio;

  assign ratio = io_clk_mhz / FREQ_W'(RATIO);

  ubs_refcnt #(.CNT_W(REF_W)) u_refcnt (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req), .go(go)
  );

  ubs_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
  );

  ubs_portcfg #(
    .NUM_PORTS(NUM_PORTS), .VREF_W(4), .RISE_W(2), .PRE_W(2),
    .VREF_VAL(15), .RISE_VAL(1), .PRE_VAL(1)
  ) u_portcfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr),
    .vref(port_vref_tune), .rise(port_rise_tune), .pre(port_preemph_tune)
  );

  // Next state and wait-counter loads.
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cfg_wr   = 1'b0;
    unique case (state_q)
      ST_IDLE:     if (go) state_d = ST_IFEN;
      ST_IFEN:     state_d = ST_CHECK;
      ST_CHECK:    state_d = host_rst_n ? ST_PORTS : ST_INIT;
      ST_INIT:     state_d = ST_HDIV;
      ST_HDIV:     state_d = ST_HDIV_EN;
      ST_HDIV_EN:  state_d = ST_HDIV_REL;
      ST_HDIV_REL: begin
        state_d = ST_WAIT_A; tmr_load = 1'b1; tmr_val = TMR_W'(DIV_WAIT - 1);
      end
      ST_WAIT_A:   if (tmr_done) state_d = ST_POR_REL;
      ST_POR_REL:  begin
        state_d = ST_WAIT_MS; tmr_load = 1'b1; tmr_val = TMR_W'(W_MS - 1);
      end
      ST_WAIT_MS:  if (tmr_done) state_d = ST_TRST_ON;
      ST_TRST_ON:  begin
        state_d = ST_WAIT_P; tmr_load = 1'b1; tmr_val = TMR_W'(W_PULSE - 1);
      end
      ST_WAIT_P:   if (tmr_done) state_d = ST_TRST_OFF;
      ST_TRST_OFF: begin
        state_d = ST_WAIT_S; tmr_load = 1'b1; tmr_val = TMR_W'(W_SETTLE - 1);
      end
      ST_WAIT_S:   if (tmr_done) state_d = ST_ODIV_REL;
      ST_ODIV_REL: state_d = ST_ODIV_EN;
      ST_ODIV_EN:  begin
        state_d = ST_WAIT_B; tmr_load = 1'b1; tmr_val = TMR_W'(DIV_WAIT - 1);
      end
      ST_WAIT_B:   if (tmr_done) state_d = ST_PRST_REL;
      ST_PRST_REL: begin
        state_d = ST_WAIT_US; tmr_load = 1'b1; tmr_val = TMR_W'(W_US - 1);
      end
      ST_WAIT_US:  if (tmr_done) state_d = ST_HRST_REL;
      ST_HRST_REL: state_d = ST_PORTS;
      ST_PORTS:    begin state_d = ST_IDLE; cfg_wr = 1'b1; end
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Registered control outputs, each changed only by its own step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_clk_en     <= 1'b0;
      phy_por       <= 1'b1;
      phy_test_rst  <= 1'b0;
      phy_rst_n     <= 1'b0;
      host_rst_n    <= 1'b0;
      hdiv_en       <= 1'b0;
      hdiv_rst_n    <= 1'b0;
      odiv_en       <= 1'b0;
      odiv_rst_n    <= 1'b0;
      hdiv_val      <= '0;
      frame_len_adj <= '0;
      busy          <= 1'b0;
      done          <= 1'b0;
    end else begin
      done <= (state_q == ST_PORTS);
      unique case (state_q)
        ST_IDLE:     if (go) busy <= 1'b1;
        ST_IFEN:     if_clk_en <= 1'b1;
        ST_INIT: begin
          phy_por    <= 1'b1;
          host_rst_n <= 1'b0;
          phy_rst_n  <= 1'b0;
          hdiv_rst_n <= 1'b0;
          odiv_rst_n <= 1'b0;
          hdiv_en    <= 1'b0;
          odiv_en    <= 1'b0;
        end
        ST_HDIV:     hdiv_val <= pick_hdiv(32'(ratio));
        ST_HDIV_EN:  hdiv_en <= 1'b1;
        ST_HDIV_REL: hdiv_rst_n <= 1'b1;
        ST_POR_REL:  phy_por <= 1'b0;
        ST_TRST_ON:  phy_test_rst <= 1'b1;
        ST_TRST_OFF: phy_test_rst <= 1'b0;
        ST_ODIV_REL: odiv_rst_n <= 1'b1;
        ST_ODIV_EN:  odiv_en <= 1'b1;
        ST_PRST_REL: phy_rst_n <= 1'b1;
        ST_HRST_REL: host_rst_n <= 1'b1;
        ST_PORTS: begin
          busy          <= 1'b0;
          frame_len_adj <= FLA_W'(FLA_VAL);
        end
        default: ;
      endcase
    end
  end

  p_ifen_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> if_clk_en)
    else $error("interface clock not enabled after launch");

  p_hdiv_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hdiv_en |-> (hdiv_val inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12}))
    else $error("host divider ratio outside the table");

  p_hdiv_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdiv_rst_n) |-> hdiv_en)
    else $error("host divider left reset before being enabled");

  p_por_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_por) |-> (hdiv_rst_n && hdiv_en))
    else $error("power-on reset released before host divider runs");

  p_odiv_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(odiv_en) |-> odiv_rst_n)
    else $error("OHCI divider enabled while still in reset");

  p_host_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rst_n) |-> (phy_rst_n && !phy_por && !phy_test_rst && odiv_en))
    else $error("host reset released before the PHY was ready");

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("completion pulse longer than one cycle");

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && frame_len_adj == FLA_W'(FLA_VAL)))
    else $error("completion without final programming");

endmodule

// File: tb/sim_usb_bringup_seq.sv
module sim_usb_bringup_seq;
  localparam int unsigned KHZ = 2500;
  localparam int NP = 2;
  localparam int DIVW = 64;
  localparam int E_MS = int'($ceil(real'(KHZ) * 1.0));
  localparam int E_US = int'($ceil(real'(KHZ) / 1000.0));
  localparam int E_P  = int'($ceil(real'(KHZ) * 10.0 / 1.0e6));
  localparam int E_S  = int'($ceil(real'(KHZ) * 20.0 / 1.0e6));

  localparam int A_IFEN = 1, A_CHECK = 2, A_INIT = 3, A_HDIV = 4, A_HEN = 5,
                 A_HREL = 6, A_POR = 7, A_TON = 8, A_TOFF = 9, A_OREL = 10,
                 A_OEN = 11, A_PREL = 12, A_HOST = 13, A_PORTS = 14;

  logic clk = 1'b0, rst_n = 1'b0, start_req = 1'b0, stop_req = 1'b0;
  logic [11:0] io_clk_mhz = 12'd650;
  logic if_clk_en, phy_por, phy_test_rst, phy_rst_n, host_rst_n;
  logic hdiv_en, hdiv_rst_n, odiv_en, odiv_rst_n, busy, done;
  logic [3:0] hdiv_val;
  logic [NP*4-1:0] port_vref_tune;
  logic [NP*2-1:0] port_rise_tune, port_preemph_tune;
  logic [5:0] frame_len_adj;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  usb_bringup_seq #(.IO_CLK_KHZ(KHZ), .NUM_PORTS(NP), .DIV_WAIT(DIVW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .io_clk_mhz(io_clk_mhz), .if_clk_en(if_clk_en), .phy_por(phy_por),
    .phy_test_rst(phy_test_rst), .phy_rst_n(phy_rst_n), .host_rst_n(host_rst_n),
    .hdiv_en(hdiv_en), .hdiv_rst_n(hdiv_rst_n), .odiv_en(odiv_en),
    .odiv_rst_n(odiv_rst_n), .hdiv_val(hdiv_val), .port_vref_tune(port_vref_tune),
    .port_rise_tune(port_rise_tune), .port_preemph_tune(port_preemph_tune),
    .frame_len_adj(frame_len_adj), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int exp_div(input int mhz);
    int q;
    q = mhz / 130;
    if (q == 0) return 1;
    if (q <= 4) return q;
    if (q == 5) return 4;
    if (q <= 7) return 6;
    if (q <= 11) return 8;
    return 12;
  endfunction

  // Behavioural reference model: schedule of (gap, action) pairs.
  int gapq[$], actq[$];
  int m_cnt, m_wait;
  bit m_ifen, m_por, m_test, m_phy, m_host, m_hen, m_hrst, m_oen, m_orst;
  bit m_busy, m_done, m_cfg;
  int m_hdiv;

  function automatic void push(input int g, input int a);
    gapq.push_back(g);
    actq.push_back(a);
  endfunction

  function automatic void apply(input int a);
    case (a)
      A_IFEN:  m_ifen = 1;
      A_CHECK: if (m_host) begin gapq.delete(); actq.delete(); push(1, A_PORTS); end
      A_INIT:  begin m_por = 1; m_host = 0; m_phy = 0; m_hrst = 0; m_orst = 0;
                     m_hen = 0; m_oen = 0; end
      A_HDIV:  m_hdiv = exp_div(int'(io_clk_mhz));
      A_HEN:   m_hen = 1;
      A_HREL:  m_hrst = 1;
      A_POR:   m_por = 0;
      A_TON:   m_test = 1;
      A_TOFF:  m_test = 0;
      A_OREL:  m_orst = 1;
      A_OEN:   m_oen = 1;
      A_PREL:  m_phy = 1;
      A_HOST:  m_host = 1;
      A_PORTS: begin m_busy = 0; m_done = 1; m_cfg = 1; end
      default: ;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapq.delete(); actq.delete();
      m_cnt = 0; m_wait = 0; m_ifen = 0; m_por = 1; m_test = 0; m_phy = 0;
      m_host = 0; m_hen = 0; m_hrst = 0; m_oen = 0; m_orst = 0;
      m_busy = 0; m_done = 0; m_cfg = 0; m_hdiv = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      m_done = 0;
      if (actq.size() > 0) begin
        m_wait--;
        if (m_wait == 0) begin
          int a;
          a = actq.pop_front();
          void'(gapq.pop_front());
          apply(a);
          if (actq.size() > 0) m_wait = gapq[0];
        end
      end
      if (start_req && !stop_req && m_cnt == 0 && !was_busy) begin
        m_busy = 1;
        push(1, A_IFEN); push(1, A_CHECK); push(1, A_INIT); push(1, A_HDIV);
        push(1, A_HEN); push(1, A_HREL); push(DIVW + 1, A_POR);
        push(E_MS + 1, A_TON); push(E_P + 1, A_TOFF); push(E_S + 1, A_OREL);
        push(1, A_OEN); push(DIVW + 1, A_PREL); push(E_US + 1, A_HOST);
        push(1, A_PORTS);
        m_wait = gapq[0];
      end
      if (start_req && !stop_req && m_cnt < 255) m_cnt++;
      else if (stop_req && !start_req && m_cnt > 0) m_cnt--;
    end
  end

  // Per-cycle comparison and direct duration measurements.
  int por_fall_cyc = 0, prst_rise_cyc = 0;
  logic prev_por = 1'b1, prev_test = 1'b0, prev_prst = 1'b0, prev_host = 1'b0;

  always @(negedge clk) begin
    cyc++;
    chk("R3", "if_clk_en", int'(if_clk_en), int'(m_ifen));
    chk("R6", "phy_por", int'(phy_por), int'(m_por));
    chk("R6", "phy_test_rst", int'(phy_test_rst), int'(m_test));
    chk("R7", "phy_rst_n", int'(phy_rst_n), int'(m_phy));
    chk("R8", "host_rst_n", int'(host_rst_n), int'(m_host));
    chk("R5", "hdiv_en", int'(hdiv_en), int'(m_hen));
    chk("R5", "hdiv_rst_n", int'(hdiv_rst_n), int'(m_hrst));
    chk("R7", "odiv_en", int'(odiv_en), int'(m_oen));
    chk("R7", "odiv_rst_n", int'(odiv_rst_n), int'(m_orst));
    chk("R4", "hdiv_val", int'(hdiv_val), m_hdiv);
    chk("R2", "busy", int'(busy), int'(m_busy));
    chk("R9", "done", int'(done), int'(m_done));
    chk("R9", "vref", int'(port_vref_tune), m_cfg ? 8'hFF : 0);
    chk("R9", "rise", int'(port_rise_tune), m_cfg ? 4'b0101 : 0);
    chk("R9", "preemph", int'(port_preemph_tune), m_cfg ? 4'b0101 : 0);
    chk("R9", "frame_len_adj", int'(frame_len_adj), m_cfg ? 32 : 0);
    if (rst_n) begin
      if (prev_por && !phy_por) por_fall_cyc = cyc;
      if (!prev_test && phy_test_rst) chk("R10", "1ms wait", cyc - por_fall_cyc, E_MS + 1);
      if (!prev_prst && phy_rst_n) prst_rise_cyc = cyc;
      if (!prev_host && host_rst_n) chk("R10", "1us wait", cyc - prst_rise_cyc, E_US + 1);
    end
    prev_por = phy_por; prev_test = phy_test_rst;
    prev_prst = phy_rst_n; prev_host = host_rst_n;
    if (cyc == 150000) begin
      chk("R2", "watchdog cycles", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk); #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #3 rst_n = 1'b1;
  endtask

  task automatic pulse(input bit s, input bit p);
    @(negedge clk); start_req = s; stop_req = p;
    @(negedge clk); start_req = 1'b0; stop_req = 1'b0;
  endtask

  task automatic wait_done(input string req);
    bit seen;
    seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(req, "done seen", int'(seen), 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int mhz_list[10];
    mhz_list = '{129, 130, 520, 650, 780, 1000, 1040, 1559, 1560, 4095};
    do_reset();
    @(negedge clk);
    // R1: initial state after reset
    chk("R1", "phy_por", int'(phy_por), 1);
    chk("R1", "if_clk_en", int'(if_clk_en), 0);
    chk("R1", "host_rst_n", int'(host_rst_n), 0);
    chk("R1", "phy_rst_n", int'(phy_rst_n), 0);
    chk("R1", "div resets", int'({hdiv_rst_n, odiv_rst_n}), 0);
    chk("R1", "div enables", int'({hdiv_en, odiv_en}), 0);
    chk("R1", "busy/done", int'({busy, done}), 0);
    chk("R1", "frame_len_adj", int'(frame_len_adj), 0);

    // R2: stop at zero and simultaneous start/stop do nothing
    pulse(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk("R2", "busy after floor stop", int'(busy), 0);
    pulse(1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R2", "busy after start+stop", int'(busy), 0);

    // Full run; a second start while busy only counts
    io_clk_mhz = 12'd650;
    pulse(1'b1, 1'b0);
    repeat (100) @(negedge clk);
    pulse(1'b1, 1'b0);
    wait_done("R9");
    chk("R4", "hdiv for 650 MHz", int'(hdiv_val), 4);
    chk("R8", "host released", int'(host_rst_n), 1);

    // Count now 2: another start does nothing; stops never tear down
    pulse(1'b1, 1'b0);
    repeat (6) @(negedge clk);
    chk("R2", "busy on non-first start", int'(busy), 0);
    pulse(1'b0, 1'b1); pulse(1'b0, 1'b1); pulse(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk("R2", "host kept after stops", int'(host_rst_n), 1);

    // Count back at 0: new start runs the skip path (R3)
    pulse(1'b1, 1'b0);
    wait_done("R3");
    chk("R3", "phy_por stays released", int'(phy_por), 0);

    // Divider table sweep (R4)
    foreach (mhz_list[k]) begin
      do_reset();
      io_clk_mhz = 12'(mhz_list[k]);
      pulse(1'b1, 1'b0);
      wait_done("R4");
      chk("R4", $sformatf("hdiv for %0d MHz", mhz_list[k]), int'(hdiv_val),
          exp_div(mhz_list[k]));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule